// File: doc/BRIEF.md
# Infrared Receiver Sample FIFO and Status Block

This block is the runtime register block of a consumer-infrared receiver. The demodulated IR input is resynchronised and then sampled once per sample period. Each unbroken run of carrier (pulse) or silence (space) is measured in sample periods and packed into one byte. Bit 7 of that byte gives the polarity and bits 6:0 give the run length. The bytes go into a FIFO, and the host drains the FIFO one byte per read of the receive-data register.

A status register holds four event flags and a global interrupt enable. The flags are: data received, receive timeout, transmit underrun and transmit finished. Each flag is cleared by writing 1 to it. The interrupt enable gates a registered, level-sensitive interrupt output. The transmit path lies outside this block. It only reports its two events through single-cycle input strobes.

The host reaches the block over a small synchronous register port. Writes take effect at the clock edge on which `bus_wr` is sampled high. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high. The register map is:
- 0: status
- 1: receive data
- 2: sample-period select
- 3: idle threshold
- 4: read-only class

Any other address reads as zero.

Top module: `ir_rx_top`

## Requirements
- R1: Status bit 0 is set when a byte is stored, bit 1 on a receive timeout, bit 2 when `tx_urun_evt` is high and bit 3 when `tx_fin_evt` is high.
- R2: Writing status with a 1 in bit 2 or bit 3 clears that flag, and writing 0 there leaves it unchanged. Status bit 7 is the interrupt enable and takes the written value.
- R3: `irq` is high exactly when the interrupt enable and at least one flag were both set one cycle earlier, and it stays low whenever the enable is clear.
- R4: Each read of address 1 returns the oldest stored byte and removes it. Status bits 0 and 1 stay set while the FIFO holds any byte, even when they are written with 1.
- R5: Each stored byte carries the polarity in bit 7 (1 = pulse, 0 = space) and the run length in sample periods in bits 6:0.
- R6: Address 2 bits 1:0 select the sample period: 00 = 50 us, 01 = 1 us, 10 = 25 us, 11 = 100 us. Writing this register restarts the period timer.
- R7: Address 4 is read-only and returns the transmitter count (0, 1 or 2) set by parameter; writes to it have no effect.
- R8: A run that reaches 127 periods is stored as a byte with length 127, and counting restarts for the same polarity. A run of exactly 127 periods produces a single byte.
- R9: Once the space has lasted the number of periods in address 3, the pending space run is stored and the block returns to idle. Status bit 1 is set if the FIFO then holds data. A threshold of 0 disables the timeout, and spaces seen while idle are not recorded.
- R10: A read of address 1 while the FIFO is empty returns 0x00 and changes no state.
- R11: When the FIFO holds `FIFO_DEPTH` bytes, newly measured bytes are dropped and the stored ones are kept intact.
- R12: After reset the status, period select and interrupt output are 0, and the idle threshold equals `TOUT_RST` (default 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated IR level, 1 = carrier present |
| tx_urun_evt | input | 1 | Transmit underrun strobe |
| tx_fin_evt | input | 1 | Transmit finished strobe |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume `ir_in` is a plain level that may change in any cycle, since the block resynchronises it. They further assume that the idle threshold is never 1, because at 1 the pulse byte and the trailing space byte would fall due in the same period. The stimulus drives each run for an exact multiple of the sample period and issues bus reads and writes one at a time. It always programs thresholds of 0 or at least 10. The expected byte stream and flags come from a behavioural model of runs, saturation and the idle rule.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

  localparam int BUS_W = 8;
  localparam int PER_W = 7;

  typedef enum logic [2:0] {
    A_STAT  = 3'd0,
    A_DATA  = 3'd1,
    A_CTRL  = 3'd2,
    A_TOUT  = 3'd3,
    A_CLASS = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    PER_50US  = 2'b00,
    PER_1US   = 2'b01,
    PER_25US  = 2'b10,
    PER_100US = 2'b11
  } per_sel_e;

  localparam int ST_RXD = 0;
  localparam int ST_RXT = 1;
  localparam int ST_TXU = 2;
  localparam int ST_TXF = 3;
  localparam int ST_IE  = 7;

  function automatic logic [PER_W-1:0] period_us(input logic [1:0] sel);
    case (sel)
      PER_1US:   period_us = PER_W'(1);
      PER_25US:  period_us = PER_W'(25);
      PER_100US: period_us = PER_W'(100);
      default:   period_us = PER_W'(50);
    endcase
  endfunction

endpackage

// File: rtl/ir_rx_tick.sv
module ir_rx_tick
  import ir_rx_pkg::*;
#(
  parameter int CLK_PER_US = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       tick
);

  logic             us_stb;
  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] per_lim;

  generate
    if (CLK_PER_US > 1) begin : g_div
      localparam int UW = $clog2(CLK_PER_US);
      logic [UW-1:0] us_cnt;
      always_ff @(posedge clk) begin
        if (rst || restart) us_cnt <= '0;
        else if (us_cnt == UW'(CLK_PER_US - 1)) us_cnt <= '0;
        else us_cnt <= us_cnt + 1'b1;
      end
      assign us_stb = (us_cnt == UW'(CLK_PER_US - 1));
    end else begin : g_nodiv
      assign us_stb = 1'b1;
    end
  endgenerate

  assign per_lim = period_us(sel) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      per_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (us_stb) begin
        if (per_cnt >= per_lim) begin
          per_cnt <= '0;
          tick    <= 1'b1;
        end else begin
          per_cnt <= per_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ir_rx_runlen.sv
module ir_rx_runlen #(
  parameter int DUR_W = 7,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ir_in,
  input  logic [THR_W-1:0] tout_thr,
  output logic             push,
  output logic [DUR_W:0]   push_byte,
  output logic             tout_evt
);

  localparam int MAXC = (1 << DUR_W) - 1;

  logic             s1, lvl;
  logic             act, act_n;
  logic             pol, pol_n;
  logic [DUR_W-1:0] cnt, cnt_n;
  logic [THR_W-1:0] idle, idle_n;
  logic             emit, tev;
  logic [DUR_W:0]   ebyte;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      lvl <= 1'b0;
    end else begin
      s1  <= ir_in;
      lvl <= s1;
    end
  end

  always_comb begin
    act_n  = act;
    pol_n  = pol;
    cnt_n  = cnt;
    idle_n = idle;
    emit   = 1'b0;
    ebyte  = '0;
    tev    = 1'b0;
    if (tick) begin
      if (!act) begin
        if (lvl) begin
          act_n  = 1'b1;
          pol_n  = 1'b1;
          cnt_n  = DUR_W'(1);
          idle_n = '0;
        end
      end else begin
        if (lvl == pol) begin
          if (cnt == DUR_W'(MAXC - 1)) begin
            emit  = 1'b1;
            ebyte = {pol, DUR_W'(MAXC)};
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end else begin
          if (cnt != '0) begin
            emit  = 1'b1;
            ebyte = {pol, cnt};
          end
          pol_n = lvl;
          cnt_n = DUR_W'(1);
        end
        if (lvl) idle_n = '0;
        else if (idle != '1) idle_n = idle + 1'b1;
        if (!lvl && (tout_thr != '0) && (idle_n >= tout_thr)) begin
          tev = 1'b1;
          if (!emit && (cnt_n != '0)) begin
            emit  = 1'b1;
            ebyte = {1'b0, cnt_n};
          end
          act_n  = 1'b0;
          pol_n  = 1'b0;
          cnt_n  = '0;
          idle_n = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b0;
      pol       <= 1'b0;
      cnt       <= '0;
      idle      <= '0;
      push      <= 1'b0;
      push_byte <= '0;
      tout_evt  <= 1'b0;
    end else begin
      act       <= act_n;
      pol       <= pol_n;
      cnt       <= cnt_n;
      idle      <= idle_n;
      push      <= emit;
      push_byte <= ebyte;
      tout_evt  <= tev;
    end
  end

  AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (rst) cnt != DUR_W'(MAXC)); // R8
  AST_PUSH_AFTER_TICK: assert property (@(posedge clk) disable iff (rst) push |-> $past(tick)); // R5
  AST_TOUT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst) tout_evt |-> $past(tick)); // R9

endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              q,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
    if (do_pop) q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= (AW+1)'(DEPTH)); // R11
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst) (full && push && !pop) |=> full); // R11

endmodule

// File: rtl/ir_rx_top.sv
module ir_rx_top
  import ir_rx_pkg::*;
#(
  parameter int         CLK_PER_US = 50,
  parameter int         FIFO_DEPTH = 16,
  parameter int         DUR_W      = 7,
  parameter int         TX_COUNT   = 1,
  parameter logic [7:0] TOUT_RST   = 8'd64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ir_in,
  input  logic       tx_urun_evt,
  input  logic       tx_fin_evt,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);

  localparam int BW  = DUR_W + 1;
  localparam int CW  = $clog2(FIFO_DEPTH) + 1;
  localparam int THR_W = 8;

  logic [3:0]       flags;
  logic             ie;
  logic [1:0]       per_sel;
  logic [THR_W-1:0] tout_thr;
  logic [7:0]       reg_q;
  logic             data_sel;

  logic             tick;
  logic             push;
  logic [BW-1:0]    push_byte;
  logic             tout_evt;
  logic [BW-1:0]    fifo_q;
  logic [CW-1:0]    fifo_count;
  logic             fifo_empty, fifo_full;

  logic             wr_stat, wr_ctrl, wr_tout, rd_data, pop;
  logic             rx_clear_ok;

  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_tout = bus_wr && (bus_addr == A_TOUT);
  assign rd_data = bus_rd && (bus_addr == A_DATA);
  assign pop     = rd_data && !fifo_empty;
  assign rx_clear_ok = fifo_empty && !push;

  ir_rx_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .sel(per_sel), .restart(wr_ctrl), .tick(tick)
  );

  ir_rx_runlen #(.DUR_W(DUR_W), .THR_W(THR_W)) u_runlen (
    .clk(clk), .rst(rst), .tick(tick), .ir_in(ir_in), .tout_thr(tout_thr),
    .push(push), .push_byte(push_byte), .tout_evt(tout_evt)
  );

  ir_rx_fifo #(.DW(BW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(push_byte), .pop(pop),
    .q(fifo_q), .count(fifo_count), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      ie       <= 1'b0;
      per_sel  <= PER_50US;
      tout_thr <= TOUT_RST;
      irq      <= 1'b0;
    end else begin
      irq <= ie && (flags != '0);

      if (push) flags[ST_RXD] <= 1'b1;
      else if (wr_stat && bus_wdata[ST_RXD] && rx_clear_ok) flags[ST_RXD] <= 1'b0;

      if (tout_evt && (!fifo_empty || push)) flags[ST_RXT] <= 1'b1;
      else if (wr_stat && bus_wdata[ST_RXT] && rx_clear_ok) flags[ST_RXT] <= 1'b0;

      if (tx_urun_evt) flags[ST_TXU] <= 1'b1;
      else if (wr_stat && bus_wdata[ST_TXU]) flags[ST_TXU] <= 1'b0;

      if (tx_fin_evt) flags[ST_TXF] <= 1'b1;
      else if (wr_stat && bus_wdata[ST_TXF]) flags[ST_TXF] <= 1'b0;

      if (wr_stat) ie <= bus_wdata[ST_IE];
      if (wr_ctrl) per_sel <= bus_wdata[1:0];
      if (wr_tout) tout_thr <= bus_wdata[THR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      data_sel <= 1'b0;
    end else if (bus_rd) begin
      data_sel <= pop;
      case (bus_addr)
        A_STAT:  reg_q <= {ie, 3'b000, flags};
        A_CTRL:  reg_q <= {6'b0, per_sel};
        A_TOUT:  reg_q <= 8'(tout_thr);
        A_CLASS: reg_q <= 8'(TX_COUNT);
        default: reg_q <= '0;
      endcase
    end
  end

  assign bus_rdata = data_sel ? BUS_W'(fifo_q) : reg_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst) !ie |=> !irq); // R3
  AST_RXD_HELD: assert property (@(posedge clk) disable iff (rst) (fifo_count != '0) |-> flags[ST_RXD]); // R4
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_data && fifo_empty) |=> (bus_rdata == 8'h00)); // R10
  AST_EMPTY_READ_KEEP: assert property (@(posedge clk) disable iff (rst) (rd_data && fifo_empty && !push) |=> (fifo_count == '0)); // R10

endmodule

// File: tb/ir_rx_top_tb.sv
module ir_rx_top_tb;

  localparam int THR = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ir_in = 1'b0;
  logic       tx_urun_evt = 1'b0;
  logic       tx_fin_evt = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  byte unsigned expq[$];
  int thr_m = THR;

  always #10 clk = ~clk;

  ir_rx_top #(.CLK_PER_US(1)) u_dut (
    .clk(clk), .rst(rst), .ir_in(ir_in), .tx_urun_evt(tx_urun_evt),
    .tx_fin_evt(tx_fin_evt), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ir_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expq.delete();
  endtask

  task automatic mpush(input byte unsigned b);
    if (expq.size() < 16) expq.push_back(b);
  endtask

  task automatic run(input bit lv, input int n, input int per);
    int left = n;
    ir_in = lv;
    repeat (n * per) @(negedge clk);
    while (left >= 127) begin
      mpush(lv ? 8'hFF : 8'h7F);
      left -= 127;
    end
    if (left > 0) mpush({lv, 7'(left)});
  endtask

  task automatic finish_msg(input int per);
    ir_in = 1'b0;
    repeat ((thr_m + 4) * per + 8) @(negedge clk);
    mpush(8'(thr_m));
  endtask

  task automatic drain(input string req);
    logic [7:0] d;
    while (expq.size() > 0) begin
      rd(3'd1, d);
      chk(req, d, expq.pop_front());
    end
    rd(3'd1, d);
    chk("R10 empty read", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R12 reset values
    rd(3'd0, d); chk("R12 status", d, 0);
    rd(3'd2, d); chk("R12 ctrl", d, 0);
    rd(3'd3, d); chk("R12 threshold", d, 8'h40);
    chk("R12 irq", irq, 0);
    // R7 class register, write ignored
    wr(3'd4, 8'hFF);
    rd(3'd4, d); chk("R7 class", d, 1);

    // R6 default 50 us period
    wr(3'd3, 8'(THR)); thr_m = THR;
    run(1'b1, 3, 50);
    finish_msg(50);
    rd(3'd0, d); chk("R1 status no ie", d, 8'h03);
    chk("R3 irq off without enable", irq, 0);
    drain("R6 50us bytes");

    // R5 R9 basic burst at 1 us
    do_reset();
    wr(3'd2, 8'h01); wr(3'd3, 8'(THR)); wr(3'd0, 8'h80);
    run(1'b1, 5, 1); run(1'b0, 3, 1); run(1'b1, 7, 1);
    finish_msg(1);
    rd(3'd0, d); chk("R1 R9 status", d, 8'h83);
    chk("R3 irq on", irq, 1);
    wr(3'd0, 8'h83);
    rd(3'd0, d); chk("R4 flags held while data", d, 8'h83);
    drain("R5 byte format");
    rd(3'd0, d); chk("R10 status after empty read", d, 8'h83);
    wr(3'd0, 8'h83);
    rd(3'd0, d); chk("R4 flags cleared when empty", d, 8'h80);
    chk("R3 irq dropped", irq, 0);

    // R1 R2 tx flags
    @(negedge clk); tx_urun_evt = 1'b1; @(negedge clk); tx_urun_evt = 1'b0;
    rd(3'd0, d); chk("R1 underrun", d, 8'h84);
    chk("R3 irq on tx", irq, 1);
    wr(3'd0, 8'h88);
    rd(3'd0, d); chk("R2 write0 keeps", d, 8'h84);
    wr(3'd0, 8'h84);
    rd(3'd0, d); chk("R2 w1c", d, 8'h80);
    @(negedge clk); tx_fin_evt = 1'b1; @(negedge clk); tx_fin_evt = 1'b0;
    wr(3'd0, 8'h00);
    rd(3'd0, d); chk("R1 finished with ie off", d, 8'h08);
    chk("R3 irq gated", irq, 0);
    wr(3'd0, 8'h08);
    rd(3'd0, d); chk("R2 cleared", d, 0);

    // R8 saturation
    run(1'b1, 300, 1);
    finish_msg(1);
    drain("R8 long pulse");
    run(1'b1, 127, 1);
    finish_msg(1);
    drain("R8 exact 127");

    // R6 25 us and 100 us
    wr(3'd2, 8'h02);
    rd(3'd2, d); chk("R6 ctrl readback", d, 2);
    run(1'b1, 4, 25);
    finish_msg(25);
    drain("R6 25us bytes");
    wr(3'd2, 8'h03);
    run(1'b1, 2, 100);
    finish_msg(100);
    drain("R6 100us bytes");

    // R9 threshold 0 disables timeout
    do_reset();
    wr(3'd2, 8'h01); wr(3'd3, 8'h00); wr(3'd0, 8'h80);
    ir_in = 1'b1; repeat (4) @(negedge clk);
    ir_in = 1'b0; repeat (200) @(negedge clk);
    rd(3'd0, d); chk("R9 no timeout at thr 0", d, 8'h81);
    rd(3'd1, d); chk("R9 pulse byte", d, 8'h84);
    rd(3'd1, d); chk("R9 saturated space", d, 8'h7F);

    // R11 overflow
    do_reset();
    wr(3'd2, 8'h01); wr(3'd3, 8'(THR)); thr_m = THR;
    for (int i = 0; i < 10; i++) begin
      run(1'b1, 2, 1);
      if (i < 9) run(1'b0, 2, 1);
    end
    finish_msg(1);
    chk("R11 model depth", expq.size(), 16);
    drain("R11 kept bytes");

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule